// File: doc/BRIEF.md
# SDRAM Bank Precharge Tracker

This block watches the command pins that a memory controller drives toward an SDRAM. It keeps a record of which of the banks hold an open row, which are idle, and which are still in their row-precharge recovery. The commands it acts on are row activation, read, write, precharge (one bank or every bank) and burst stop. A per-bank `bank_ready` bit tells the controller's scheduler that an activation may be sent to that bank on the current cycle. A `violation` pulse marks any command that the memory would not accept in that bank's present state.

Reads and writes may ask for an automatic close of their bank at the end of the burst. This happens by holding address bit 10 high on that one command. The tracker counts the burst itself, closes the bank at the earliest legal point, and then applies the same recovery delay that an explicit precharge would. A burst stop, or a newer read or write, ends the current burst early, so any automatic close it carried begins at that edge. In full-page mode the automatic close does not apply.

The recovery delay, the burst length and the full-page selection are static configuration inputs. Commands are sampled on the rising clock edge, and both outputs come from registered state.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A precharge with `addr_bit10`=1 closes every bank that holds an open row, whatever `bank_addr` carries. Banks that were already idle keep their countdown.
- R2: A precharge with `addr_bit10`=0 closes only the bank selected by `bank_addr`. A precharge sent to an idle bank has no effect.
- R3: Suppose a bank closes at edge E with `cfg_trp`=N≥1. Its `bank_ready` bit is low after E and rises after edge E+N-1, so an activation at edge E+N is accepted. For N=0 the behaviour is the same as for N=1. An accepted activation opens the bank and clears its `bank_ready` bit after that edge.
- R4: A read or write sent to a bank that is idle or still in recovery raises `violation` after that edge and changes no state.
- R5: An activation sent to a bank whose `bank_ready` bit is low raises `violation` after that edge and is ignored.
- R6: A read or write with `addr_bit10`=1 arms an automatic close when full-page mode is off. The bank closes at the edge `cfg_burst_len` cycles after the command, where a value of 0 counts as 1. Until then, any read, write, activation or single-bank precharge to that bank is a violation and is ignored.
- R7: The automatic close applies only to the command that carried it. A later read or write with `addr_bit10`=0 leaves its bank open.
- R8: When `cfg_full_page`=1, `addr_bit10` on a read or write is ignored, and the bank stays open until it is precharged.
- R9: A burst stop ends the most recent read or write burst. If that burst had armed an automatic close, the close happens at the burst-stop edge.
- R10: A legal read or write ends the burst in progress. If that burst had armed an automatic close, its bank closes at that edge.
- R11: After reset every bank is idle and ready, and `violation` is low.
- R12: A command is decoded only while `cmd_cs_n`=0, from {`cmd_ras_n`,`cmd_cas_n`,`cmd_we_n`}: 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop. Every other pattern, and any cycle with `cmd_cs_n`=1, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_cs_n | input | 1 | Command select, active low |
| cmd_ras_n | input | 1 | Row strobe pin of the command |
| cmd_cas_n | input | 1 | Column strobe pin of the command |
| cmd_we_n | input | 1 | Write-enable pin of the command |
| addr_bit10 | input | 1 | Precharge-all on precharge; automatic close on read/write |
| bank_addr | input | BA_W | Target bank |
| cfg_trp | input | TRP_W | Row-precharge delay in clock cycles |
| cfg_burst_len | input | BL_W | Burst length in cycles |
| cfg_full_page | input | 1 | Full-page burst mode |
| bank_ready | output | BANKS | Bank may accept an activation this cycle |
| violation | output | 1 | Previous command was illegal |

## Verification
Every result of a command sampled at edge T becomes visible right after T. This holds for the `violation` pulse, for a bank leaving the ready set, and for a bank entering recovery. A bank's ready bit then returns after edge T+`cfg_trp`-1. An automatic close starts at edge T+`cfg_burst_len`, or earlier at a burst stop or an interrupting read or write. The bench turns each of these rules into an absolute cycle number at the moment it drives the command, and queues the expected outputs for that cycle. A monitor compares them on the falling edge of that exact cycle, so an early or late change fails the check.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_BST
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_CLOSING
  } bank_st_e;

  // Pin-level command decode; deselected cycles decode as no-operation.
  function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                       input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
  import sbt_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2
) (
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             a10,
  input  logic [BA_W-1:0]  ba,
  output cmd_e             cmd,
  output logic [BANKS-1:0] bank_sel,
  output logic             pre_all
);

  logic targeted;

  always_comb begin
    cmd      = decode_pins(cs_n, ras_n, cas_n, we_n);
    pre_all  = (cmd == CMD_PRE) && a10;
    targeted = (cmd == CMD_ACT) || is_access(cmd) || ((cmd == CMD_PRE) && !a10);
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign bank_sel[b] = targeted && (ba == BA_W'(b));
  end

endmodule

// File: rtl/sbt_bank_slot.sv
module sbt_bank_slot
  import sbt_pkg::*;
#(
  parameter int TRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             pre_all,
  input  logic             ap_close,
  input  logic             arm_ap,
  input  logic [TRP_W-1:0] cfg_trp,
  output logic             ready,
  output logic             viol
);

  bank_st_e         st;
  logic [TRP_W-1:0] wait_cnt;
  logic             accept;
  logic             close_now;

  // Remaining recovery cycles after the closing edge itself.
  function automatic logic [TRP_W-1:0] trp_load(input logic [TRP_W-1:0] t);
    return (t == '0) ? '0 : t - TRP_W'(1);
  endfunction

  always_comb begin
    ready = (st == BK_IDLE) && (wait_cnt == '0);
    viol  = sel && (((cmd == CMD_ACT) && !ready) ||
                    (is_access(cmd) && (st != BK_OPEN)) ||
                    ((cmd == CMD_PRE) && (st == BK_CLOSING)));
    accept    = sel && !viol;
    close_now = (pre_all && (st != BK_IDLE)) || ap_close ||
                (accept && (cmd == CMD_PRE) && (st == BK_OPEN));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= BK_IDLE;
      wait_cnt <= '0;
    end else if (close_now) begin
      st       <= BK_IDLE;
      wait_cnt <= trp_load(cfg_trp);
    end else if (accept && (cmd == CMD_ACT)) begin
      st <= BK_OPEN;
    end else if (accept && is_access(cmd) && arm_ap) begin
      st <= BK_CLOSING;
    end else if ((st == BK_IDLE) && (wait_cnt != '0)) begin
      wait_cnt <= wait_cnt - TRP_W'(1);
    end
  end

endmodule

// File: rtl/sbt_burst_tracker.sv
module sbt_burst_tracker #(
  parameter int BANKS = 4,
  parameter int BL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BANKS-1:0] start_bank,
  input  logic             start_ap,
  input  logic             full_page,
  input  logic             bst,
  input  logic             pre_all,
  input  logic [BL_W-1:0]  cfg_bl,
  output logic [BANKS-1:0] ap_close
);

  logic             busy;
  logic             fp;
  logic             ap;
  logic [BL_W-1:0]  cnt;
  logic [BANKS-1:0] bank;
  logic             expire;
  logic             cut;

  function automatic logic [BL_W-1:0] burst_load(input logic [BL_W-1:0] bl);
    return (bl == '0) ? BL_W'(1) : bl;
  endfunction

  always_comb begin
    expire   = busy && !fp && (cnt == BL_W'(1));
    cut      = busy && (bst || start || expire);
    ap_close = (cut && ap) ? bank : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fp   <= 1'b0;
      ap   <= 1'b0;
      cnt  <= '0;
      bank <= '0;
    end else if (start) begin
      busy <= 1'b1;
      fp   <= full_page;
      ap   <= start_ap && !full_page;
      cnt  <= burst_load(cfg_bl);
      bank <= start_bank;
    end else if (cut || pre_all) begin
      busy <= 1'b0;
      ap   <= 1'b0;
    end else if (busy && !fp) begin
      cnt <= cnt - BL_W'(1);
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int  BANKS = 4,
  parameter int  TRP_W = 4,
  parameter int  BL_W  = 4,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_cs_n,
  input  logic             cmd_ras_n,
  input  logic             cmd_cas_n,
  input  logic             cmd_we_n,
  input  logic             addr_bit10,
  input  logic [BA_W-1:0]  bank_addr,
  input  logic [TRP_W-1:0] cfg_trp,
  input  logic [BL_W-1:0]  cfg_burst_len,
  input  logic             cfg_full_page,
  output logic [BANKS-1:0] bank_ready,
  output logic             violation
);

  cmd_e             cmd;
  logic [BANKS-1:0] bank_sel;
  logic             pre_all;
  logic [BANKS-1:0] slot_viol;
  logic [BANKS-1:0] ap_close;
  logic             any_viol;
  logic             burst_start;
  logic             start_ap;
  logic             violation_q;

  sbt_cmd_decode #(.BANKS(BANKS), .BA_W(BA_W)) u_dec (
    .cs_n     (cmd_cs_n),
    .ras_n    (cmd_ras_n),
    .cas_n    (cmd_cas_n),
    .we_n     (cmd_we_n),
    .a10      (addr_bit10),
    .ba       (bank_addr),
    .cmd      (cmd),
    .bank_sel (bank_sel),
    .pre_all  (pre_all)
  );

  always_comb begin
    any_viol    = |slot_viol;
    start_ap    = addr_bit10 && !cfg_full_page;
    burst_start = is_access(cmd) && !any_viol;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sbt_bank_slot #(.TRP_W(TRP_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .sel      (bank_sel[b]),
      .pre_all  (pre_all),
      .ap_close (ap_close[b]),
      .arm_ap   (start_ap),
      .cfg_trp  (cfg_trp),
      .ready    (bank_ready[b]),
      .viol     (slot_viol[b])
    );
  end

  sbt_burst_tracker #(.BANKS(BANKS), .BL_W(BL_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (burst_start),
    .start_bank (bank_sel),
    .start_ap   (start_ap),
    .full_page  (cfg_full_page),
    .bst        (cmd == CMD_BST),
    .pre_all    (pre_all),
    .cfg_bl     (cfg_burst_len),
    .ap_close   (ap_close)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) violation_q <= 1'b0;
    else        violation_q <= any_viol;
  end

  assign violation = violation_q;

endmodule

// File: rtl/sbt_tracker_checker.sv
module sbt_tracker_checker
  import sbt_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int TRP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input cmd_e             cmd,
  input logic [BANKS-1:0] bank_sel,
  input logic             pre_all,
  input logic [BANKS-1:0] bank_ready,
  input logic             violation,
  input logic [BANKS-1:0] ap_close,
  input logic [TRP_W-1:0] cfg_trp,
  input logic             cfg_full_page
);

  // R12: at most one bank addressed, none on precharge-all
  p_single_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel) && !(pre_all && (bank_sel != '0)));

  // R4: access to a ready (idle) bank is flagged
  p_access_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_access(cmd) && ((bank_sel & bank_ready) != '0)) |=> violation);

  // R5: activation of a bank that is not ready is flagged
  p_act_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_ACT) && ((bank_sel & ~bank_ready) != '0)) |=> violation);

  // R3: accepted activation opens the bank without a violation
  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_ACT) && ((bank_sel & bank_ready) != '0))
      |=> (!violation && ((bank_ready & $past(bank_sel)) == '0)));

  // R6: automatic close leaves the bank in recovery when the delay exceeds one
  p_ap_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ap_close != '0) && (cfg_trp > TRP_W'(1)))
      |=> ((bank_ready & $past(ap_close)) == '0));

  // R6: automatic close targets at most one bank
  p_ap_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ap_close));

  // R8: no automatic close in full-page mode
  p_full_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_full_page |-> (ap_close == '0));

endmodule

bind sdram_bank_tracker sbt_tracker_checker #(.BANKS(BANKS), .TRP_W(TRP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd           (cmd),
  .bank_sel      (bank_sel),
  .pre_all       (pre_all),
  .bank_ready    (bank_ready),
  .violation     (violation),
  .ap_close      (ap_close),
  .cfg_trp       (cfg_trp),
  .cfg_full_page (cfg_full_page)
);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_DES = 4'b1011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n, ras_n, cas_n, we_n;
  logic       a10;
  logic [1:0] ba;
  logic [3:0] trp;
  logic [3:0] bl;
  logic       fpage;
  logic [3:0] ready;
  logic       viol;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    int         due;
    logic [3:0] rdy;
    logic       vio;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t rest[$];

  always #5 clk = ~clk;

  sdram_bank_tracker u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_cs_n      (cs_n),
    .cmd_ras_n     (ras_n),
    .cmd_cas_n     (cas_n),
    .cmd_we_n      (we_n),
    .addr_bit10    (a10),
    .bank_addr     (ba),
    .cfg_trp       (trp),
    .cfg_burst_len (bl),
    .cfg_full_page (fpage),
    .bank_ready    (ready),
    .violation     (viol)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Monitor: compare queued expectations in the cycle they fall due.
  always @(negedge clk) begin
    if (rst_n) begin
      rest = {};
      foreach (q[i]) begin
        if (q[i].due == cyc) begin
          n_checks++;
          if (ready !== q[i].rdy || viol !== q[i].vio) begin
            n_fail++;
            $display("FAIL %s cycle %0d: ready=%b violation=%b expected ready=%b violation=%b",
                     q[i].tag, cyc, ready, viol, q[i].rdy, q[i].vio);
          end
        end else begin
          rest.push_back(q[i]);
        end
      end
      q = rest;
    end
  end

  task automatic expect_at(input int due, input logic [3:0] r, input logic v, input string tag);
    exp_t e;
    e.due = due; e.rdy = r; e.vio = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic hi, output int t);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba  = b;
    a10 = hi;
    t   = cyc + 1;
  endtask

  task automatic tick();
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    a10 = 1'b0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (R1..R12 flow): actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int t;
    {cs_n, ras_n, cas_n, we_n} = P_NOP;
    a10 = 1'b0; ba = 2'd0;
    trp = 4'd3; bl = 4'd4; fpage = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    expect_at(cyc + 1, 4'hF, 1'b0, "R11");
    tick();

    // R3 / R5 activation and recovery on bank 0
    issue(P_ACT, 2'd0, 1'b0, t); expect_at(t, 4'hE, 1'b0, "R3 open"); tick();
    issue(P_ACT, 2'd0, 1'b0, t); expect_at(t, 4'hE, 1'b1, "R5 open bank"); tick();
    issue(P_PRE, 2'd0, 1'b0, t);
    expect_at(t, 4'hE, 1'b0, "R2 single close");
    expect_at(t + 1, 4'hE, 1'b1, "R5 in recovery");
    expect_at(t + 2, 4'hF, 1'b0, "R3 ready edge");
    expect_at(t + 3, 4'hE, 1'b0, "R3 act accepted");
    tick();
    issue(P_ACT, 2'd0, 1'b0, t); tick();
    tick();
    issue(P_ACT, 2'd0, 1'b0, t); tick();

    // R2 / R1 precharge variants
    issue(P_ACT, 2'd1, 1'b0, t); expect_at(t, 4'hC, 1'b0, "R3 open b1"); tick();
    issue(P_PRE, 2'd3, 1'b0, t); expect_at(t, 4'hC, 1'b0, "R2 idle bank"); tick();
    issue(P_PRE, 2'd2, 1'b1, t);
    expect_at(t, 4'hC, 1'b0, "R1 all closed");
    expect_at(t + 1, 4'hC, 1'b0, "R1 recovery");
    expect_at(t + 2, 4'hF, 1'b0, "R1 ready");
    tick(); nop(2);

    // R6 automatic close after the burst
    issue(P_ACT, 2'd2, 1'b0, t); expect_at(t, 4'hB, 1'b0, "R3 open b2"); tick();
    issue(P_RD, 2'd2, 1'b1, t);
    expect_at(t, 4'hB, 1'b0, "R6 armed");
    expect_at(t + 2, 4'hB, 1'b1, "R6 access while closing");
    expect_at(t + 5, 4'hB, 1'b0, "R6 recovery");
    expect_at(t + 6, 4'hF, 1'b0, "R6 ready");
    tick(); tick();
    issue(P_RD, 2'd2, 1'b0, t); tick();
    nop(4);

    // R7 no carry-over of the automatic close
    issue(P_ACT, 2'd0, 1'b0, t); expect_at(t, 4'hE, 1'b0, "R3 open b0"); tick();
    issue(P_WR, 2'd0, 1'b0, t);
    expect_at(t, 4'hE, 1'b0, "R7 write");
    expect_at(t + 4, 4'hE, 1'b0, "R7 burst end");
    expect_at(t + 6, 4'hE, 1'b0, "R7 still open");
    tick(); nop(6);

    // R8 full-page mode
    fpage = 1'b1;
    issue(P_RD, 2'd0, 1'b1, t);
    expect_at(t, 4'hE, 1'b0, "R8 read");
    expect_at(t + 5, 4'hE, 1'b0, "R8 open");
    expect_at(t + 8, 4'hE, 1'b0, "R8 still open");
    tick(); nop(8);
    issue(P_BST, 2'd0, 1'b0, t); expect_at(t, 4'hE, 1'b0, "R8 stop"); tick();
    fpage = 1'b0;

    // R9 burst stop moves the automatic close
    issue(P_ACT, 2'd1, 1'b0, t); expect_at(t, 4'hC, 1'b0, "R3 open b1"); tick();
    issue(P_RD, 2'd1, 1'b1, t); expect_at(t, 4'hC, 1'b0, "R9 armed"); tick();
    issue(P_BST, 2'd0, 1'b0, t);
    expect_at(t, 4'hC, 1'b0, "R9 stop");
    expect_at(t + 1, 4'hC, 1'b0, "R9 recovery");
    expect_at(t + 2, 4'hE, 1'b0, "R9 early ready");
    tick(); nop(2);

    // R10 interrupting access starts the pending close
    issue(P_ACT, 2'd2, 1'b0, t); expect_at(t, 4'hA, 1'b0, "R3 open b2"); tick();
    issue(P_ACT, 2'd3, 1'b0, t); expect_at(t, 4'h2, 1'b0, "R3 open b3"); tick();
    issue(P_WR, 2'd2, 1'b1, t); expect_at(t, 4'h2, 1'b0, "R10 armed"); tick();
    issue(P_RD, 2'd3, 1'b0, t);
    expect_at(t, 4'h2, 1'b0, "R10 interrupt");
    expect_at(t + 1, 4'h2, 1'b0, "R10 recovery");
    expect_at(t + 2, 4'h6, 1'b0, "R10 early ready");
    tick(); nop(2);

    // R4 / R12 illegal accesses and deselect
    issue(P_RD, 2'd1, 1'b0, t); expect_at(t, 4'h6, 1'b1, "R4 idle bank"); tick();
    issue(P_DES, 2'd1, 1'b0, t); expect_at(t, 4'h6, 1'b0, "R12 deselected"); tick();
    issue(P_PRE, 2'd0, 1'b0, t);
    expect_at(t, 4'h6, 1'b0, "R2 close b0");
    expect_at(t + 1, 4'h6, 1'b1, "R4 in recovery");
    expect_at(t + 2, 4'h7, 1'b0, "R3 ready b0");
    tick();
    issue(P_WR, 2'd0, 1'b0, t); tick();
    nop(3);

    // R3 / R6 boundaries: delay of one cycle, burst of one cycle
    trp = 4'd1; bl = 4'd1;
    issue(P_PRE, 2'd3, 1'b0, t); expect_at(t, 4'hF, 1'b0, "R3 delay one"); tick();
    issue(P_ACT, 2'd3, 1'b0, t); expect_at(t, 4'h7, 1'b0, "R3 immediate act"); tick();
    issue(P_RD, 2'd3, 1'b1, t);
    expect_at(t, 4'h7, 1'b0, "R6 short burst");
    expect_at(t + 1, 4'hF, 1'b0, "R6 short close");
    tick(); nop(3);

    foreach (q[i]) begin
      n_checks++;
      n_fail++;
      $display("FAIL %s: actual=unchecked expected=checked at cycle %0d", q[i].tag, q[i].due);
    end
    finished = 1;
    summary();
    $finish;
  end

endmodule